// File: doc/BRIEF.md
# Multi-Mode Transfer Address Counter

This block is the datapath of a descriptor-driven data mover. Once a descriptor has been loaded onto its inputs, a one-cycle start pulse makes it step through the data items of one trigger. For each item it issues a read at the current source pointer and a write at the current destination pointer in the same cycle. It then advances both pointers by the item size in the direction configured for each side, and updates its counters. When the trigger's work is finished, it raises a one-cycle done pulse. With that pulse it presents the updated pointers and counts, an end-of-count flag and an interrupt-request flag, so that surrounding logic can write the descriptor back.

Three counting behaviours are supported. Normal mode moves one item per trigger against a 16-bit count. Repeat mode cycles endlessly over a small area on one chosen side. Block mode moves a whole block per trigger and counts blocks. In repeat and block modes, the side chosen as the area side rewinds to the start of its area whenever the area is used up. The start address is recomputed from the current pointer, so it is never stored.

Top module: `xfer_addr_ctr`

## Requirements
- R1: After reset, rd_req_o, wr_req_o, busy_o, done_o, irq_o and end_o are all 0.
- R2: Item size code 0, 1 and 2 gives 1, 2 and 4 bytes (code 3 acts as 4 bytes). Each side's step code is chosen independently: 1 adds the item size after each item, 2 subtracts it, and 0 or 3 leaves the pointer unchanged.
- R3: In normal mode (mode code 0, code 3 acts the same), a start moves exactly one item and cnt_a drops by 1 modulo 2^16. A loaded count of 0 becomes 0xFFFF and does not signal end.
- R4: In normal mode, when cnt_a goes from 1 to 0, the done pulse carries end_o = 1 and irq_o = 1.
- R5: In repeat mode (mode code 1), cnt_a[15:8] is the area size (0 means 256) and cnt_a[7:0] is a running count that drops by 1 per item. When an item is moved with the running count at 1, the count reloads from the area size. At that point the area-side pointer (destination when area_dst_i = 1, else source) moves back by size × item bytes against its step direction, which returns it to the start of the area. The other pointer keeps stepping.
- R6: Repeat mode never raises irq_o or end_o, whatever irq_each_i says.
- R7: In block mode (mode code 2), one start moves cnt_a[15:8] items (0 means 256), one read/write pair per cycle back to back. The running byte cnt_a[7:0] counts them and is reloaded to the block size at the end. The area-side pointer returns to the block start, and the other pointer keeps its advance.
- R8: In block mode, cnt_b drops by 1 once per block and holds during the block. When it goes from 1 to 0, the done pulse carries end_o = 1 and irq_o = 1.
- R9: With irq_each_i = 1, every done pulse in normal or block mode carries irq_o = 1. With irq_each_i = 0, irq_o is raised only together with end_o.
- R10: done_o is a single-cycle pulse in the cycle after the last item's request. A start seen while busy_o = 1 is ignored: no extra items are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; loads descriptor inputs when idle |
| mode_i | input | 2 | 0 normal, 1 repeat, 2 block, 3 as normal |
| size_i | input | 2 | Item size code: 0 byte, 1 halfword, 2 word, 3 as word |
| src_step_i | input | 2 | Source update: 0 fixed, 1 increment, 2 decrement, 3 fixed |
| dst_step_i | input | 2 | Destination update, same coding |
| area_dst_i | input | 1 | 1: destination is the repeat/block side; 0: source |
| irq_each_i | input | 1 | 1: request on every done; 0: only on end of count |
| src_i | input | AW | Loaded source pointer |
| dst_i | input | AW | Loaded destination pointer |
| cnt_a_i | input | CW | Loaded transfer count / size and running count |
| cnt_b_i | input | CW | Loaded block count |
| rd_req_o | output | 1 | Read request for the current item |
| rd_addr_o | output | AW | Read address |
| wr_req_o | output | 1 | Write request for the current item |
| wr_addr_o | output | AW | Write address |
| busy_o | output | 1 | Items of a trigger are being issued |
| done_o | output | 1 | One-cycle pulse: trigger finished, fields valid |
| src_o | output | AW | Updated source pointer |
| dst_o | output | AW | Updated destination pointer |
| cnt_a_o | output | CW | Updated count field A |
| cnt_b_o | output | CW | Updated count field B |
| end_o | output | 1 | Count exhausted (with done) |
| irq_o | output | 1 | Interrupt request (with done) |

## Verification
A corrupted pointer or step shows up at the very next request as a wrong read or write address, so the scoreboard catches it within one cycle of the error. A wrong rewind amount or area side appears on the first request after the area boundary. A mistake in a running count or block count moves the done pulse earlier or later, or changes the issued item count, which appears as an unexpected or missing request. The count values are also compared at each done pulse. Interrupt and end mistakes are visible only on the done cycle, so every trigger compares both flags there, including across a run of repeat-mode triggers that must stay silent.

// File: rtl/xac_pkg.sv
package xac_pkg;

    typedef enum logic [1:0] {
        M_NORMAL = 2'd0,
        M_REPEAT = 2'd1,
        M_BLOCK  = 2'd2,
        M_ALT    = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        S_FIXED = 2'd0,
        S_INC   = 2'd1,
        S_DEC   = 2'd2,
        S_HOLD  = 2'd3
    } step_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_MOVE = 1'b1
    } phase_e;

endpackage

// File: rtl/xac_stepper.sv
module xac_stepper
    import xac_pkg::*;
#(
    parameter int AW = 32,
    parameter int HW = 8
) (
    input  logic [AW-1:0] ptr_i,
    input  step_e         step_i,
    input  logic [1:0]    sz_i,
    input  logic          rewind_i,
    input  logic [HW:0]   area_i,
    output logic [AW-1:0] ptr_o
);
    localparam int PADW = AW - HW - 1;

    logic [AW-1:0] delta;
    logic [AW-1:0] span;
    logic [AW-1:0] stepped;
    logic [AW-1:0] rewound;

    always_comb begin
        delta = {{(AW-1){1'b0}}, 1'b1} << sz_i;
        span  = {{PADW{1'b0}}, area_i} << sz_i;
        case (step_i)
            S_INC: begin
                stepped = ptr_i + delta;
                rewound = stepped - span;
            end
            S_DEC: begin
                stepped = ptr_i - delta;
                rewound = stepped + span;
            end
            default: begin
                stepped = ptr_i;
                rewound = ptr_i;
            end
        endcase
        ptr_o = rewind_i ? rewound : stepped;
    end

endmodule

// File: rtl/xac_count.sv
module xac_count
    import xac_pkg::*;
#(
    parameter int CW = 16
) (
    input  mode_e          mode_i,
    input  logic [CW-1:0]  cnt_a_i,
    input  logic [CW-1:0]  cnt_b_i,
    output logic [CW-1:0]  cnt_a_o,
    output logic [CW-1:0]  cnt_b_o,
    output logic [CW/2:0]  area_o,
    output logic           last_o,
    output logic           wrap_o,
    output logic           end_o
);
    localparam int HW = CW / 2;

    logic [HW-1:0] hi;
    logic [HW-1:0] lo;
    logic [HW-1:0] lo_n;
    logic          lo_one;

    always_comb begin
        hi     = cnt_a_i[CW-1:HW];
        lo     = cnt_a_i[HW-1:0];
        lo_one = (lo == {{(HW-1){1'b0}}, 1'b1});
        area_o = (hi == '0) ? {1'b1, {HW{1'b0}}} : {1'b0, hi};
        lo_n   = lo_one ? hi : lo - 1'b1;

        cnt_a_o = cnt_a_i;
        cnt_b_o = cnt_b_i;
        last_o  = 1'b1;
        wrap_o  = 1'b0;
        end_o   = 1'b0;

        case (mode_i)
            M_REPEAT: begin
                cnt_a_o = {hi, lo_n};
                wrap_o  = lo_one;
            end
            M_BLOCK: begin
                cnt_a_o = {hi, lo_n};
                wrap_o  = lo_one;
                last_o  = lo_one;
                if (lo_one) begin
                    cnt_b_o = cnt_b_i - 1'b1;
                    end_o   = (cnt_b_i == {{(CW-1){1'b0}}, 1'b1});
                end
            end
            default: begin
                cnt_a_o = cnt_a_i - 1'b1;
                end_o   = (cnt_a_i == {{(CW-1){1'b0}}, 1'b1});
            end
        endcase
    end

endmodule

// File: rtl/xfer_addr_ctr.sv
module xfer_addr_ctr
    import xac_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [1:0]    mode_i,
    input  logic [1:0]    size_i,
    input  logic [1:0]    src_step_i,
    input  logic [1:0]    dst_step_i,
    input  logic          area_dst_i,
    input  logic          irq_each_i,
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] dst_i,
    input  logic [CW-1:0] cnt_a_i,
    input  logic [CW-1:0] cnt_b_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          wr_req_o,
    output logic [AW-1:0] wr_addr_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [AW-1:0] src_o,
    output logic [AW-1:0] dst_o,
    output logic [CW-1:0] cnt_a_o,
    output logic [CW-1:0] cnt_b_o,
    output logic          end_o,
    output logic          irq_o
);
    localparam int HW    = CW / 2;
    localparam int SIDES = 2;

    typedef struct packed {
        phase_e                     st;
        mode_e                      mode;
        logic [1:0]                 sz;
        step_e [SIDES-1:0]          step;
        logic                       area_dst;
        logic                       irq_each;
        logic [SIDES-1:0][AW-1:0]   ptr;
        logic [CW-1:0]              ca;
        logic [CW-1:0]              cb;
        logic                       done;
        logic                       irq;
        logic                       endc;
    } ctr_state_t;

    ctr_state_t q, d;

    logic [CW-1:0]            ca_nxt;
    logic [CW-1:0]            cb_nxt;
    logic [HW:0]              area_len;
    logic                     cnt_last;
    logic                     cnt_wrap;
    logic                     cnt_end;
    logic [SIDES-1:0][AW-1:0] ptr_nxt;
    logic [SIDES-1:0]         rewind;

    xac_count #(.CW(CW)) u_count (
        .mode_i  (q.mode),
        .cnt_a_i (q.ca),
        .cnt_b_i (q.cb),
        .cnt_a_o (ca_nxt),
        .cnt_b_o (cb_nxt),
        .area_o  (area_len),
        .last_o  (cnt_last),
        .wrap_o  (cnt_wrap),
        .end_o   (cnt_end)
    );

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        assign rewind[s] = cnt_wrap && (q.area_dst == (s == 1));
        xac_stepper #(.AW(AW), .HW(HW)) u_step (
            .ptr_i    (q.ptr[s]),
            .step_i   (q.step[s]),
            .sz_i     (q.sz),
            .rewind_i (rewind[s]),
            .area_i   (area_len),
            .ptr_o    (ptr_nxt[s])
        );
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.irq  = 1'b0;
        d.endc = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st       = ST_MOVE;
                    d.mode     = mode_e'(mode_i);
                    d.sz       = (size_i == 2'd3) ? 2'd2 : size_i;
                    d.step[0]  = step_e'(src_step_i);
                    d.step[1]  = step_e'(dst_step_i);
                    d.area_dst = area_dst_i;
                    d.irq_each = irq_each_i;
                    d.ptr[0]   = src_i;
                    d.ptr[1]   = dst_i;
                    d.ca       = cnt_a_i;
                    d.cb       = cnt_b_i;
                end
            end
            default: begin
                d.ptr = ptr_nxt;
                d.ca  = ca_nxt;
                d.cb  = cb_nxt;
                if (cnt_last) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    d.endc = cnt_end;
                    d.irq  = (q.mode != M_REPEAT) && (q.irq_each || cnt_end);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o    = (q.st == ST_MOVE);
    assign rd_req_o  = busy_o;
    assign wr_req_o  = busy_o;
    assign rd_addr_o = q.ptr[0];
    assign wr_addr_o = q.ptr[1];
    assign src_o     = q.ptr[0];
    assign dst_o     = q.ptr[1];
    assign cnt_a_o   = q.ca;
    assign cnt_b_o   = q.cb;
    assign done_o    = q.done;
    assign irq_o     = q.irq;
    assign end_o     = q.endc;

    // R2
    fixed_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (q.step[0] == S_FIXED || q.step[0] == S_HOLD)) |=> $stable(src_o));

    // R3
    normal_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && q.mode == M_NORMAL) |=> (cnt_a_o == $past(cnt_a_o) - 1'b1));

    // R6
    repeat_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == M_REPEAT) |-> (!irq_o && !end_o));

    // R8
    block_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && q.mode == M_BLOCK && !cnt_last) |=> $stable(cnt_b_o));

    // R9
    irq_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> done_o);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: tb/tb_xfer_addr_ctr.sv
module tb_xfer_addr_ctr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  mode_i = '0, size_i = '0, src_step_i = '0, dst_step_i = '0;
    logic        area_dst_i = 1'b0, irq_each_i = 1'b0;
    logic [31:0] src_i = '0, dst_i = '0;
    logic [15:0] cnt_a_i = '0, cnt_b_i = '0;
    logic        rd_req_o, wr_req_o, busy_o, done_o, end_o, irq_o;
    logic [31:0] rd_addr_o, wr_addr_o, src_o, dst_o;
    logic [15:0] cnt_a_o, cnt_b_o;

    xfer_addr_ctr dut (.*);

    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";
    logic [63:0] exp_q[$];

    // model of the descriptor
    logic [1:0]  g_mode, g_sz, g_ss, g_ds;
    logic        g_adst, g_each;
    logic [31:0] m_ptr[2];
    logic [15:0] m_a, m_b;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // monitor: pops one expected read/write pair per request cycle
    always @(negedge clk) begin
        if (rst_n && rd_req_o) begin
            if (exp_q.size() == 0) begin
                chk(cur_req, "unexpected item", {rd_addr_o, wr_addr_o}, 64'h0);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                chk(cur_req, "item rd/wr addr", {rd_addr_o, wr_addr_o}, e);
                chk(cur_req, "wr_req with rd_req", {63'h0, wr_req_o}, 64'h1);
            end
        end
    end

    task automatic cfg(input logic [1:0] md, input logic [1:0] sz,
                       input logic [1:0] ss, input logic [1:0] ds,
                       input logic adst, input logic each,
                       input logic [31:0] s, input logic [31:0] dd,
                       input logic [15:0] a, input logic [15:0] b);
        g_mode = md; g_sz = sz; g_ss = ss; g_ds = ds; g_adst = adst; g_each = each;
        m_ptr[0] = s; m_ptr[1] = dd; m_a = a; m_b = b;
    endtask

    function automatic logic [31:0] step_ptr(input logic [31:0] p, input logic [1:0] st,
                                            input int bytes);
        if (st == 2'd1) return p + bytes;
        if (st == 2'd2) return p - bytes;
        return p;
    endfunction

    task automatic trigger(input string req, input bit inject_busy_start);
        logic exp_irq, exp_end, last, wrap;
        int bytes, area, guard;
        logic [7:0] hi, lo;
        cur_req = req;
        mode_i = g_mode; size_i = g_sz; src_step_i = g_ss; dst_step_i = g_ds;
        area_dst_i = g_adst; irq_each_i = g_each;
        src_i = m_ptr[0]; dst_i = m_ptr[1]; cnt_a_i = m_a; cnt_b_i = m_b;
        bytes = (g_sz == 2'd0) ? 1 : (g_sz == 2'd1) ? 2 : 4;
        exp_end = 1'b0;
        last = 1'b0;
        while (!last) begin
            exp_q.push_back({m_ptr[0], m_ptr[1]});
            hi = m_a[15:8]; lo = m_a[7:0];
            area = (hi == 0) ? 256 : int'(hi);
            wrap = 1'b0; last = 1'b1;
            if (g_mode == 2'd1 || g_mode == 2'd2) begin
                if (lo == 8'd1) begin lo = hi; wrap = 1'b1; end
                else lo = lo - 8'd1;
                m_a = {hi, lo};
                if (g_mode == 2'd2) begin
                    last = wrap;
                    if (wrap) begin exp_end = (m_b == 16'd1); m_b = m_b - 16'd1; end
                end
            end else begin
                exp_end = (m_a == 16'd1);
                m_a = m_a - 16'd1;
            end
            m_ptr[0] = step_ptr(m_ptr[0], g_ss, bytes);
            m_ptr[1] = step_ptr(m_ptr[1], g_ds, bytes);
            if (wrap) begin
                int sd;
                logic [1:0] stp;
                sd = g_adst ? 1 : 0;
                stp = g_adst ? g_ds : g_ss;
                if (stp == 2'd1) m_ptr[sd] = m_ptr[sd] - area * bytes;
                else if (stp == 2'd2) m_ptr[sd] = m_ptr[sd] + area * bytes;
            end
        end
        exp_irq = (g_mode != 2'd1) && (g_each || exp_end);

        @(negedge clk) start_i = 1'b1;
        @(negedge clk);
        if (inject_busy_start) @(negedge clk);
        start_i = 1'b0;
        guard = 0;
        while (!done_o && guard < 400) begin @(negedge clk); guard++; end
        chk(req, "done pulse", {63'h0, done_o}, 64'h1);
        chk(req, "src_o", {32'h0, src_o}, {32'h0, m_ptr[0]});
        chk(req, "dst_o", {32'h0, dst_o}, {32'h0, m_ptr[1]});
        chk(req, "cnt_a_o", {48'h0, cnt_a_o}, {48'h0, m_a});
        chk(req, "cnt_b_o", {48'h0, cnt_b_o}, {48'h0, m_b});
        chk(req, "irq_o", {63'h0, irq_o}, {63'h0, exp_irq});
        chk(req, "end_o", {63'h0, end_o}, {63'h0, exp_end});
        chk(req, "items left", 64'(exp_q.size()), 64'h0);
        @(negedge clk);
        chk("R10", "done single cycle", {63'h0, done_o}, 64'h0);
        chk("R10", "idle after done", {63'h0, busy_o}, 64'h0);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "rd_req", {63'h0, rd_req_o}, 64'h0);
        chk("R1", "busy", {63'h0, busy_o}, 64'h0);
        chk("R1", "done/irq/end", {61'h0, done_o, irq_o, end_o}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "wr_req after release", {63'h0, wr_req_o}, 64'h0);

        // R3 R4 R9: normal, word, src inc, dst fixed, interrupt only at end
        cfg(2'd0, 2'd2, 2'd1, 2'd0, 1'b0, 1'b0, 32'h0000_1000, 32'h4000_0000, 16'd3, 16'd0);
        for (int i = 0; i < 3; i++) trigger("R4", 1'b0);

        // R3 R9: count 0 wraps to 0xFFFF, byte items, src dec, dst inc, irq every
        cfg(2'd0, 2'd0, 2'd2, 2'd1, 1'b0, 1'b1, 32'h0000_2003, 32'h0000_3000, 16'd0, 16'd0);
        trigger("R3", 1'b0);
        trigger("R9", 1'b0);

        // R2: size code 3 as word, step code 3 fixed, dst dec, mode 3 as normal
        cfg(2'd3, 2'd3, 2'd3, 2'd2, 1'b0, 1'b0, 32'h0000_5000, 32'h0000_6000, 16'd2, 16'd0);
        trigger("R2", 1'b0);
        cfg(2'd0, 2'd1, 2'd1, 2'd2, 1'b0, 1'b0, 32'h0000_5000, 32'h0000_6000, 16'd9, 16'd0);
        trigger("R2", 1'b0);

        // R5 R6: repeat, halfword, source is area (size 4), both inc, irq_each set
        cfg(2'd1, 2'd1, 2'd1, 2'd1, 1'b0, 1'b1, 32'h0000_1000, 32'h0000_8000, 16'h0404, 16'd0);
        for (int i = 0; i < 6; i++) trigger("R5", 1'b0);
        trigger("R6", 1'b0);

        // R5: repeat, destination area dec, area size 0 means 256
        cfg(2'd1, 2'd0, 2'd0, 2'd2, 1'b1, 1'b0, 32'h0000_0100, 32'h0000_9000, 16'h0002, 16'd0);
        for (int i = 0; i < 3; i++) trigger("R5", 1'b0);

        // R7 R8 R9: block of 3 bytes, destination area, two blocks, irq at end only
        cfg(2'd2, 2'd0, 2'd1, 2'd1, 1'b1, 1'b0, 32'h0000_0200, 32'h0000_0A00, 16'h0303, 16'd2);
        trigger("R7", 1'b0);
        trigger("R8", 1'b0);

        // R8 R9 R10: block of 2 words, source area dec, irq each, start during busy
        cfg(2'd2, 2'd2, 2'd2, 2'd1, 1'b0, 1'b1, 32'h0000_0C00, 32'h0000_0D00, 16'h0202, 16'd5);
        trigger("R10", 1'b1);
        trigger("R9", 1'b0);

        // R7: block size 0 means 256 items
        cfg(2'd2, 2'd0, 2'd1, 2'd1, 1'b0, 1'b0, 32'h0001_0000, 32'h0002_0000, 16'h0000, 16'd1);
        trigger("R7", 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule